// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Manager

This block keeps a single table of buffer descriptors for a simple Ethernet MAC. It also runs the two engines that walk that table. A programmable boundary splits the table in two. The entries below the boundary form the transmit ring and the entries from the boundary up to the top of the table form the receive ring. Software fills descriptors through a table port and hands each one to hardware by setting its ownership bit. The block then returns each descriptor with status written back.

The transmit engine waits on its current descriptor until software marks it ready. It then presents the buffer address, length and framing options to a frame sender and waits for a done pulse. After that pulse it writes back the retry count, hands the descriptor back to software and moves on. The receive engine takes each frame report from a frame-arrival stub. It places the length and error flags in the current empty receive descriptor, or it flags a busy drop when no empty descriptor is available. Three interrupt sources can be cleared one bit at a time and are gated by a mask onto a single interrupt line.

Top module: `eth_bd_ring_mgr`

## Requirements
- R1: After reset the registers read as follows: mode 0xA000 at address 0, interrupt source 0 at address 1, interrupt mask 0 at address 2, length limits 0x0040_0600 at address 3 and transmit count 64 at address 4. The irq output is low and tx_req is low.
- R2: Each table word is {pointer[63:32], length[31:16], control[15:0]}. With a transmit count N, indices 0..N-1 form the transmit ring and indices N..127 form the receive ring. A count write above 128 is ignored. An accepted count write restarts both rings at their first entry. A count of 128 leaves no receive ring.
- R3: tx_req rises only when transmit enable (mode bit 1) is set and the current transmit descriptor has control bit 15 (ready) set. While tx_req is high, tx_buf_addr, tx_len, tx_pad (control bit 12) and tx_add_crc (control bit 11) stay constant until tx_done. If the ready bit is clear, the engine waits on that descriptor.
- R4: On tx_done the descriptor's control word takes these values: bit 15 cleared, bits 7:4 set to tx_retry, bits 3:0 zero, and bits 14:8 kept. Source bit 0 is set only if control bit 14 (interrupt request) was set.
- R5: When a descriptor has control bit 13 (wrap) set, or is the last entry of its ring, the ring pointer returns to the first entry of that ring after that descriptor is used. The first entry is 0 for transmit and N for receive.
- R6: When receive enable (mode bit 0) is set and the current receive descriptor has bit 15 (empty) set, a frame report stores rx_len and clears bit 15. Bits 14:8 are kept. Error inputs map to control bits as follows: rx_err[0] to bit 0 (late collision), [1] to bit 1 (CRC), [2] to bit 4 (dribble), [3] to bit 5 (invalid symbol) and [4] to bit 6 (overrun). Source bit 2 is set only if control bit 14 was set.
- R7: A length below the minimum (address 3, bits 31:16) sets control bit 2. A length above the maximum (bits 15:0) sets control bit 3. A length equal to either limit sets neither bit.
- R8: A frame reported with rx_addr_miss is ignored and leaves no trace unless promiscuous mode (mode bit 5) is on. In promiscuous mode such a frame is stored with control bit 7 set.
- R9: An accepted frame with no empty receive descriptor sets source bit 4. The table is not changed and the receive pointer does not advance.
- R10: With receive enable clear, frame reports change neither the table nor the source register.
- R11: Writing a one to a source bit clears it, and writing a zero leaves it unchanged. The irq output is high when any source bit is set together with its mask bit.
- R12: While mode bit 11 is set, all source bits are cleared, both rings return to their first entry and transmit stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 mode, 1 source, 2 mask, 3 limits, 4 count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | 7 | Descriptor index for table read and write |
| tbl_wdata | input | 64 | Descriptor write data |
| tbl_rdata | output | 64 | Descriptor at tbl_idx |
| tx_req | output | 1 | Frame send request |
| tx_buf_addr | output | 32 | Buffer pointer of the frame being sent |
| tx_len | output | 16 | Byte count of the frame being sent |
| tx_pad | output | 1 | Pad short frames |
| tx_add_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Frame send finished |
| tx_retry | input | 4 | Retries used for the finished frame |
| rx_valid | input | 1 | Frame arrival report |
| rx_len | input | 16 | Received frame length |
| rx_err | input | 5 | Received frame error flags |
| rx_addr_miss | input | 1 | Destination address did not match |
| irq | output | 1 | Masked interrupt |

## Verification
A bad ring pointer shows up at the ports on the next descriptor that is handed off. A bad transmit pointer puts the wrong tx_buf_addr on tx_req one cycle after the ready bit appears. A bad receive pointer writes the length into the wrong table entry or raises busy one cycle after the frame report. A wrong ownership decision shows up as a request that never rises or a descriptor whose status changes while software owns it, which the bench sees when it reads the table back. Interrupt bookkeeping errors are visible on irq and at source address 1 in the cycle right after the event.

// File: rtl/eth_bd_pkg.sv
package eth_bd_pkg;
   localparam int CTL_OWN  = 15;
   localparam int CTL_IRQ  = 14;
   localparam int CTL_WRAP = 13;
   localparam int CTL_PAD  = 12;
   localparam int CTL_CRC  = 11;
   localparam int CTL_MISS = 7;

   localparam int SRC_TX   = 0;
   localparam int SRC_RX   = 2;
   localparam int SRC_BUSY = 4;
   localparam logic [4:0] SRC_USED = 5'b10101;

   localparam int MODE_RXEN = 0;
   localparam int MODE_TXEN = 1;
   localparam int MODE_PRO  = 5;
   localparam int MODE_SRST = 11;
   localparam logic [15:0] MODE_RST_VAL = 16'hA000;
   localparam logic [31:0] PLEN_RST_VAL = 32'h0040_0600;

   localparam logic [2:0] ADR_MODE  = 3'd0;
   localparam logic [2:0] ADR_SRC   = 3'd1;
   localparam logic [2:0] ADR_MASK  = 3'd2;
   localparam logic [2:0] ADR_PLEN  = 3'd3;
   localparam logic [2:0] ADR_TXNUM = 3'd4;

   typedef struct packed {
      logic [31:0] buf_ptr;
      logic [15:0] len;
      logic [15:0] ctrl;
   } bd_t;
endpackage

// File: rtl/eth_bd_table.sv
module eth_bd_table
   import eth_bd_pkg::*;
#(
   parameter  int DEPTH = 128,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          sw_we,
   input  logic [IW-1:0] sw_idx,
   input  bd_t           sw_wdata,
   output bd_t           sw_rdata,
   input  logic [IW-1:0] tx_idx,
   output bd_t           tx_rd,
   input  logic          tx_we,
   input  logic [15:0]   tx_ctrl,
   input  logic [IW-1:0] rx_idx,
   output bd_t           rx_rd,
   input  logic          rx_we,
   input  logic [15:0]   rx_ctrl,
   input  logic [15:0]   rx_len
);
   logic [15:0] ctrl_q [DEPTH];
   logic [15:0] len_q  [DEPTH];
   logic [31:0] ptr_q  [DEPTH];

   // engine write-backs come after the software write so they take priority
   always_ff @(posedge clk) begin
      if (sw_we) begin
         ctrl_q[sw_idx] <= sw_wdata.ctrl;
         len_q[sw_idx]  <= sw_wdata.len;
         ptr_q[sw_idx]  <= sw_wdata.buf_ptr;
      end
      if (tx_we) ctrl_q[tx_idx] <= tx_ctrl;
      if (rx_we) begin
         ctrl_q[rx_idx] <= rx_ctrl;
         len_q[rx_idx]  <= rx_len;
      end
   end

   assign sw_rdata = '{buf_ptr: ptr_q[sw_idx], len: len_q[sw_idx], ctrl: ctrl_q[sw_idx]};
   assign tx_rd    = '{buf_ptr: ptr_q[tx_idx], len: len_q[tx_idx], ctrl: ctrl_q[tx_idx]};
   assign rx_rd    = '{buf_ptr: ptr_q[rx_idx], len: len_q[rx_idx], ctrl: ctrl_q[rx_idx]};
endmodule

// File: rtl/eth_bd_regs.sv
module eth_bd_regs
   import eth_bd_pkg::*;
#(
   parameter  int DESC_CNT  = 128,
   parameter  bit IRQ_REG   = 1'b0,
   localparam int CW        = $clog2(DESC_CNT) + 1,
   localparam int TXNUM_RST = DESC_CNT / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          ev_tx,
   input  logic          ev_rx,
   input  logic          ev_busy,
   output logic          rx_en,
   output logic          tx_en,
   output logic          promisc,
   output logic          srst,
   output logic          cnt_wr,
   output logic [CW-1:0] tx_num,
   output logic [15:0]   min_len,
   output logic [15:0]   max_len,
   output logic [4:0]    int_src,
   output logic [4:0]    int_mask,
   output logic          irq
);
   logic [15:0]   mode_q;
   logic [31:0]   plen_q;
   logic [CW-1:0] txnum_q;
   logic [4:0]    src_q, mask_q, src_set, src_clr;

   assign cnt_wr = reg_we && (reg_addr == ADR_TXNUM) && (reg_wdata <= 32'(DESC_CNT));

   assign src_set = ({4'b0, ev_tx} << SRC_TX) | ({4'b0, ev_rx} << SRC_RX)
                  | ({4'b0, ev_busy} << SRC_BUSY);
   assign src_clr = (reg_we && reg_addr == ADR_SRC) ? (reg_wdata[4:0] & SRC_USED) : 5'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_RST_VAL;
         plen_q  <= PLEN_RST_VAL;
         txnum_q <= CW'(TXNUM_RST);
         mask_q  <= '0;
         src_q   <= '0;
      end else begin
         if (reg_we && reg_addr == ADR_MODE) mode_q <= reg_wdata[15:0];
         if (reg_we && reg_addr == ADR_PLEN) plen_q <= reg_wdata;
         if (reg_we && reg_addr == ADR_MASK) mask_q <= reg_wdata[4:0] & SRC_USED;
         if (cnt_wr) txnum_q <= reg_wdata[CW-1:0];
         if (mode_q[MODE_SRST]) src_q <= '0;
         else                   src_q <= (src_q & ~src_clr) | src_set;
      end
   end

   always_comb begin
      unique case (reg_addr)
         ADR_MODE:  reg_rdata = {16'b0, mode_q};
         ADR_SRC:   reg_rdata = {27'b0, src_q};
         ADR_MASK:  reg_rdata = {27'b0, mask_q};
         ADR_PLEN:  reg_rdata = plen_q;
         ADR_TXNUM: reg_rdata = {{(32-CW){1'b0}}, txnum_q};
         default:   reg_rdata = '0;
      endcase
   end

   assign rx_en    = mode_q[MODE_RXEN];
   assign tx_en    = mode_q[MODE_TXEN];
   assign promisc  = mode_q[MODE_PRO];
   assign srst     = mode_q[MODE_SRST];
   assign tx_num   = txnum_q;
   assign min_len  = plen_q[31:16];
   assign max_len  = plen_q[15:0];
   assign int_src  = src_q;
   assign int_mask = mask_q;

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(src_q & mask_q);
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |(src_q & mask_q);
      end
   endgenerate
endmodule

// File: rtl/eth_bd_tx_engine.sv
module eth_bd_tx_engine
   import eth_bd_pkg::*;
#(
   parameter  int DESC_CNT = 128,
   localparam int IW       = $clog2(DESC_CNT),
   localparam int CW       = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          tx_en,
   input  logic [CW-1:0] tx_num,
   input  bd_t           cur,
   input  logic          tx_done,
   input  logic [3:0]    tx_retry,
   output logic [IW-1:0] ptr,
   output logic          wb_we,
   output logic [15:0]   wb_ctrl,
   output logic          ev_tx,
   output logic          tx_req,
   output logic [31:0]   tx_buf_addr,
   output logic [15:0]   tx_len,
   output logic          tx_pad,
   output logic          tx_add_crc
);
   logic busy_q;
   logic [IW-1:0] ptr_q;
   logic at_last;

   assign at_last = ({1'b0, ptr_q} == (tx_num - 1'b1));
   assign wb_we   = busy_q && tx_done && !restart;
   assign wb_ctrl = {1'b0, cur.ctrl[14:8], tx_retry, 4'b0};
   assign ev_tx   = wb_we && cur.ctrl[CTL_IRQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
      end else if (restart) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
      end else if (!busy_q) begin
         if (tx_en && tx_num != '0 && cur.ctrl[CTL_OWN]) busy_q <= 1'b1;
      end else if (tx_done) begin
         busy_q <= 1'b0;
         ptr_q  <= (cur.ctrl[CTL_WRAP] || at_last) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr         = ptr_q;
   assign tx_req      = busy_q;
   assign tx_buf_addr = cur.buf_ptr;
   assign tx_len      = cur.len;
   assign tx_pad      = cur.ctrl[CTL_PAD];
   assign tx_add_crc  = cur.ctrl[CTL_CRC];
endmodule

// File: rtl/eth_bd_rx_engine.sv
module eth_bd_rx_engine
   import eth_bd_pkg::*;
#(
   parameter  int DESC_CNT = 128,
   localparam int IW       = $clog2(DESC_CNT),
   localparam int CW       = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          rx_en,
   input  logic          promisc,
   input  logic [CW-1:0] tx_num,
   input  logic [15:0]   min_len,
   input  logic [15:0]   max_len,
   input  bd_t           cur,
   input  logic          rx_valid,
   input  logic [15:0]   rx_len,
   input  logic [4:0]    rx_err,
   input  logic          rx_addr_miss,
   output logic [IW-1:0] idx,
   output logic [CW-1:0] ring_idx,
   output logic [IW-1:0] off,
   output logic          wb_we,
   output logic [15:0]   wb_ctrl,
   output logic          ev_rx,
   output logic          ev_busy
);
   logic [IW-1:0] off_q;
   logic ring_ok, accept, owned, at_last, too_short, too_long;

   // the pointer is kept as an offset from the ring boundary
   assign ring_idx  = tx_num + {1'b0, off_q};
   assign idx       = ring_idx[IW-1:0];
   assign ring_ok   = tx_num < CW'(DESC_CNT);
   assign at_last   = ring_idx == CW'(DESC_CNT - 1);
   assign accept    = rx_valid && rx_en && !restart && (!rx_addr_miss || promisc);
   assign owned     = ring_ok && cur.ctrl[CTL_OWN];
   assign too_short = rx_len < min_len;
   assign too_long  = rx_len > max_len;

   assign wb_we   = accept && owned;
   assign ev_rx   = wb_we && cur.ctrl[CTL_IRQ];
   assign ev_busy = accept && !owned;
   assign wb_ctrl = {1'b0, cur.ctrl[14:8], rx_addr_miss, rx_err[4], rx_err[3], rx_err[2],
                     too_long, too_short, rx_err[1], rx_err[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      off_q <= '0;
      else if (restart) off_q <= '0;
      else if (wb_we)   off_q <= (cur.ctrl[CTL_WRAP] || at_last) ? '0 : off_q + 1'b1;
   end

   assign off = off_q;
endmodule

// File: rtl/eth_bd_ring_mgr.sv
module eth_bd_ring_mgr
   import eth_bd_pkg::*;
#(
   parameter  int DESC_CNT = 128,
   parameter  bit IRQ_REG  = 1'b0,
   localparam int IW       = $clog2(DESC_CNT),
   localparam int CW       = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          tbl_we,
   input  logic [IW-1:0] tbl_idx,
   input  logic [63:0]   tbl_wdata,
   output logic [63:0]   tbl_rdata,
   output logic          tx_req,
   output logic [31:0]   tx_buf_addr,
   output logic [15:0]   tx_len,
   output logic          tx_pad,
   output logic          tx_add_crc,
   input  logic          tx_done,
   input  logic [3:0]    tx_retry,
   input  logic          rx_valid,
   input  logic [15:0]   rx_len,
   input  logic [4:0]    rx_err,
   input  logic          rx_addr_miss,
   output logic          irq
);
   generate
      if (DESC_CNT < 4 || (DESC_CNT & (DESC_CNT - 1)) != 0 || DESC_CNT > 32768) begin : g_bad_depth
         $error("DESC_CNT must be a power of two between 4 and 32768");
      end
   endgenerate

   logic          rx_en, tx_en, promisc, mode_srst, cnt_wr, restart;
   logic          ev_tx, ev_rx, ev_busy;
   logic [CW-1:0] tx_num, rx_ring_idx;
   logic [15:0]   min_len, max_len;
   logic [4:0]    int_src, int_mask;
   logic [IW-1:0] tx_ptr, rx_idx, rx_off;
   logic          tx_wb_we, rx_wb_we;
   logic [15:0]   tx_wb_ctrl, rx_wb_ctrl;
   bd_t           tx_cur, rx_cur, sw_rd;

   assign restart   = mode_srst || cnt_wr;
   assign tbl_rdata = sw_rd;

   eth_bd_regs #(.DESC_CNT(DESC_CNT), .IRQ_REG(IRQ_REG)) u_regs (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .ev_tx, .ev_rx, .ev_busy, .rx_en, .tx_en, .promisc,
      .srst(mode_srst), .cnt_wr, .tx_num, .min_len, .max_len,
      .int_src, .int_mask, .irq
   );

   eth_bd_table #(.DEPTH(DESC_CNT)) u_table (
      .clk, .sw_we(tbl_we), .sw_idx(tbl_idx), .sw_wdata(bd_t'(tbl_wdata)), .sw_rdata(sw_rd),
      .tx_idx(tx_ptr), .tx_rd(tx_cur), .tx_we(tx_wb_we), .tx_ctrl(tx_wb_ctrl),
      .rx_idx(rx_idx), .rx_rd(rx_cur), .rx_we(rx_wb_we), .rx_ctrl(rx_wb_ctrl), .rx_len(rx_len)
   );

   eth_bd_tx_engine #(.DESC_CNT(DESC_CNT)) u_tx (
      .clk, .rst_n, .restart, .tx_en, .tx_num, .cur(tx_cur), .tx_done, .tx_retry,
      .ptr(tx_ptr), .wb_we(tx_wb_we), .wb_ctrl(tx_wb_ctrl), .ev_tx,
      .tx_req, .tx_buf_addr, .tx_len, .tx_pad, .tx_add_crc
   );

   eth_bd_rx_engine #(.DESC_CNT(DESC_CNT)) u_rx (
      .clk, .rst_n, .restart, .rx_en, .promisc, .tx_num, .min_len, .max_len,
      .cur(rx_cur), .rx_valid, .rx_len, .rx_err, .rx_addr_miss,
      .idx(rx_idx), .ring_idx(rx_ring_idx), .off(rx_off),
      .wb_we(rx_wb_we), .wb_ctrl(rx_wb_ctrl), .ev_rx, .ev_busy
   );
endmodule

// File: rtl/eth_bd_ring_chk.sv
module eth_bd_ring_chk #(
   parameter  int DESC_CNT = 128,
   localparam int IW       = $clog2(DESC_CNT),
   localparam int CW       = IW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          restart,
   input logic          mode_srst,
   input logic          tx_req,
   input logic          tx_done,
   input logic [31:0]   tx_buf_addr,
   input logic [15:0]   tx_len,
   input logic [IW-1:0] tx_ptr,
   input logic [IW-1:0] rx_off,
   input logic [CW-1:0] tx_num,
   input logic [CW-1:0] rx_ring_idx,
   input logic          ev_busy,
   input logic [4:0]    int_src
);
   // R3
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_done && !restart) |=> (tx_req && $stable(tx_buf_addr) && $stable(tx_len)));

   // R4
   tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_done) |=> !tx_req);

   // R2
   tx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_num != '0) |-> ({1'b0, tx_ptr} < tx_num));

   // R2
   rx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_num < CW'(DESC_CNT)) |-> (rx_ring_idx >= tx_num && rx_ring_idx < CW'(DESC_CNT)));

   // R9
   busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_busy |=> int_src[4]);

   // R12
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_srst |=> (int_src == '0 && tx_ptr == '0 && rx_off == '0 && !tx_req));
endmodule

bind eth_bd_ring_mgr eth_bd_ring_chk #(.DESC_CNT(DESC_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .restart(restart), .mode_srst(mode_srst),
   .tx_req(tx_req), .tx_done(tx_done), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
   .tx_ptr(tx_ptr), .rx_off(rx_off), .tx_num(tx_num), .rx_ring_idx(rx_ring_idx),
   .ev_busy(ev_busy), .int_src(int_src)
);

// File: tb/eth_bd_ring_mgr_bench.sv
`timescale 1ns/1ps
module eth_bd_ring_mgr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tbl_we = 1'b0;
   logic [6:0]  tbl_idx = '0;
   logic [63:0] tbl_wdata = '0;
   logic [63:0] tbl_rdata;
   logic        tx_req, tx_pad, tx_add_crc, irq;
   logic [31:0] tx_buf_addr;
   logic [15:0] tx_len;
   logic        tx_done = 1'b0;
   logic [3:0]  tx_retry = '0;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_len = '0;
   logic [4:0]  rx_err = '0;
   logic        rx_addr_miss = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   eth_bd_ring_mgr u_eth_bd_ring_mgr (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .tbl_we, .tbl_idx, .tbl_wdata, .tbl_rdata,
      .tx_req, .tx_buf_addr, .tx_len, .tx_pad, .tx_add_crc, .tx_done, .tx_retry,
      .rx_valid, .rx_len, .rx_err, .rx_addr_miss, .irq
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic bd_wr(input int i, input logic [31:0] p, input logic [15:0] l, input logic [15:0] c);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 7'(i); tbl_wdata = {p, l, c};
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic bd_rd(input int i, output logic [63:0] d);
      @(negedge clk);
      tbl_idx = 7'(i);
      #1 d = tbl_rdata;
   endtask

   task automatic tx_expect(input string req, input logic [31:0] addr, input logic [15:0] len,
                            input logic [3:0] retry);
      for (int k = 0; k < 20 && !tx_req; k++) @(negedge clk);
      check({req, " tx_req"}, 64'(tx_req), 64'd1);
      check({req, " tx_buf_addr"}, 64'(tx_buf_addr), 64'(addr));
      check({req, " tx_len"}, 64'(tx_len), 64'(len));
      tx_done = 1'b1; tx_retry = retry;
      @(negedge clk);
      tx_done = 1'b0; tx_retry = '0;
   endtask

   task automatic rx_frame(input logic [15:0] l, input logic [4:0] e, input logic miss);
      @(negedge clk);
      rx_valid = 1'b1; rx_len = l; rx_err = e; rx_addr_miss = miss;
      @(negedge clk);
      rx_valid = 1'b0; rx_addr_miss = 1'b0; rx_err = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      reg_rd(3'd0, d); check("R1 mode", 64'(d), 64'h0000_A000);
      reg_rd(3'd1, d); check("R1 source", 64'(d), 64'h0);
      reg_rd(3'd2, d); check("R1 mask", 64'(d), 64'h0);
      reg_rd(3'd3, d); check("R1 limits", 64'(d), 64'h0040_0600);
      reg_rd(3'd4, d); check("R1 count", 64'(d), 64'd64);
      check("R1 irq", 64'(irq), 64'd0);
      check("R1 tx_req", 64'(tx_req), 64'd0);
   endtask

   task automatic t_setup;
      for (int i = 0; i < 8; i++) bd_wr(i, 32'h0, 16'h0, 16'h0);
      reg_wr(3'd4, 32'd4);
      reg_wr(3'd2, 32'h15);
      reg_wr(3'd0, 32'hA003);
   endtask

   task automatic t_tx_basic;
      logic [63:0] d; logic [31:0] s;
      bd_wr(0, 32'h1000, 16'd60, 16'hD800);
      for (int k = 0; k < 3; k++) @(negedge clk);
      check("R3 pad", 64'(tx_pad), 64'd1);
      check("R3 add_crc", 64'(tx_add_crc), 64'd1);
      tx_expect("R3", 32'h1000, 16'd60, 4'd3);
      bd_rd(0, d); check("R4 writeback ctrl", 64'(d[15:0]), 64'h5830);
      reg_rd(3'd1, s); check("R4 tx source", 64'(s), 64'h1);
      check("R11 irq set", 64'(irq), 64'd1);
      reg_wr(3'd1, 32'h1);
      reg_rd(3'd1, s); check("R11 w1c", 64'(s), 64'h0);
      check("R11 irq clear", 64'(irq), 64'd0);
   endtask

   task automatic t_tx_stall;
      logic [63:0] d; logic [31:0] s;
      for (int k = 0; k < 6; k++) @(negedge clk);
      check("R3 stall not ready", 64'(tx_req), 64'd0);
      bd_wr(1, 32'h2000, 16'd70, 16'h8000);
      tx_expect("R3 resume", 32'h2000, 16'd70, 4'd0);
      bd_rd(1, d); check("R4 no irq ctrl", 64'(d[15:0]), 64'h0000);
      reg_rd(3'd1, s); check("R4 no source", 64'(s), 64'h0);
   endtask

   task automatic t_tx_wrap;
      bd_wr(3, 32'h4000, 16'd80, 16'h8000);
      bd_wr(0, 32'h5000, 16'd90, 16'h8000);
      bd_wr(2, 32'h3000, 16'd50, 16'hA000);
      tx_expect("R5 wrap desc", 32'h3000, 16'd50, 4'd0);
      tx_expect("R5 wrap to 0", 32'h5000, 16'd90, 4'd0);
      bd_wr(0, 32'h8000, 16'd44, 16'h8000);
      bd_wr(2, 32'h7000, 16'd45, 16'h8000);
      bd_wr(1, 32'h6000, 16'd46, 16'h8000);
      tx_expect("R5 seq1", 32'h6000, 16'd46, 4'd0);
      tx_expect("R5 seq2", 32'h7000, 16'd45, 4'd0);
      tx_expect("R5 seq3", 32'h4000, 16'd80, 4'd0);
      tx_expect("R5 boundary wrap", 32'h8000, 16'd44, 4'd0);
   endtask

   task automatic t_rx;
      logic [63:0] d; logic [31:0] s;
      bd_wr(4, 32'h100, 16'h0, 16'hC000);
      bd_wr(5, 32'h200, 16'h0, 16'h8000);
      bd_wr(6, 32'h300, 16'h0, 16'hE000);
      rx_frame(16'd100, 5'b0, 1'b0);
      bd_rd(4, d); check("R6 first rx desc", d, {32'h100, 16'd100, 16'h4000});
      reg_rd(3'd1, s); check("R6 rx source", 64'(s), 64'h4);
      reg_wr(3'd1, 32'h4);
      rx_frame(16'd20, 5'b0, 1'b0);
      bd_rd(5, d); check("R7 short", d, {32'h200, 16'd20, 16'h0004});
      reg_rd(3'd1, s); check("R6 no irq no source", 64'(s), 64'h0);
      rx_frame(16'd2000, 5'b00010, 1'b0);
      bd_rd(6, d); check("R7 long and crc", d, {32'h300, 16'd2000, 16'h600A});
      reg_wr(3'd1, 32'h4);
      rx_frame(16'd80, 5'b0, 1'b0);
      reg_rd(3'd1, s); check("R9 busy source", 64'(s), 64'h10);
      bd_rd(4, d); check("R9 table unchanged", d, {32'h100, 16'd100, 16'h4000});
      reg_wr(3'd1, 32'h10);
      bd_wr(4, 32'h100, 16'h0, 16'hC000);
      rx_frame(16'd64, 5'b0, 1'b1);
      bd_rd(4, d); check("R8 miss ignored", d, {32'h100, 16'h0, 16'hC000});
      reg_rd(3'd1, s); check("R8 miss no source", 64'(s), 64'h0);
      reg_wr(3'd0, 32'hA023);
      rx_frame(16'd64, 5'b10000, 1'b1);
      bd_rd(4, d); check("R8 promisc accept", d, {32'h100, 16'd64, 16'h40C0});
      reg_wr(3'd0, 32'hA003);
      reg_wr(3'd1, 32'h15);
      bd_wr(5, 32'h200, 16'h0, 16'h8000);
      rx_frame(16'd1536, 5'b0, 1'b0);
      bd_rd(5, d); check("R7 equal max", d, {32'h200, 16'd1536, 16'h0000});
   endtask

   task automatic t_rx_off_and_mask;
      logic [63:0] d; logic [31:0] s;
      reg_wr(3'd0, 32'hA002);
      rx_frame(16'd90, 5'b0, 1'b0);
      reg_rd(3'd1, s); check("R10 no source", 64'(s), 64'h0);
      bd_rd(6, d); check("R10 table unchanged", d, {32'h300, 16'd2000, 16'h600A});
      reg_wr(3'd0, 32'hA003);
      rx_frame(16'd90, 5'b0, 1'b0);
      reg_wr(3'd2, 32'h5);
      check("R11 masked", 64'(irq), 64'd0);
      reg_wr(3'd2, 32'h15);
      check("R11 unmasked", 64'(irq), 64'd1);
      reg_wr(3'd1, 32'h4);
      reg_rd(3'd1, s); check("R11 w1c other bit", 64'(s), 64'h10);
   endtask

   task automatic t_soft_reset;
      logic [63:0] d; logic [31:0] s;
      reg_wr(3'd0, 32'hA803);
      reg_rd(3'd1, s); check("R12 source cleared", 64'(s), 64'h0);
      check("R12 tx idle", 64'(tx_req), 64'd0);
      reg_wr(3'd0, 32'hA003);
      bd_wr(0, 32'h9000, 16'd40, 16'h8000);
      tx_expect("R12 tx ring restart", 32'h9000, 16'd40, 4'd0);
      bd_wr(4, 32'h100, 16'h0, 16'hC000);
      rx_frame(16'd90, 5'b0, 1'b0);
      bd_rd(4, d); check("R12 rx ring restart", d, {32'h100, 16'd90, 16'h4000});
   endtask

   task automatic t_count;
      logic [31:0] s;
      reg_wr(3'd4, 32'd200);
      reg_rd(3'd4, s); check("R2 count ignored", 64'(s), 64'd4);
      reg_wr(3'd4, 32'd128);
      reg_rd(3'd4, s); check("R2 count full", 64'(s), 64'd128);
      reg_wr(3'd1, 32'h15);
      rx_frame(16'd90, 5'b0, 1'b0);
      reg_rd(3'd1, s); check("R2 no rx ring busy", 64'(s), 64'h10);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      for (int k = 0; k < 100000; k++) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_setup();
      t_tx_basic();
      t_tx_stall();
      t_tx_wrap();
      t_rx();
      t_rx_off_and_mask();
      t_soft_reset();
      t_count();
      summary();
      $finish;
   end
endmodule